// File: doc/BRIEF.md
# Paged Indirect Register Bridge

This block sits behind a management port that can reach only 32 registers of 16 bits each, and opens a 32-bit internal address space through that small window. The host side is a parallel register port (5-bit register number, 16-bit data, one-cycle read and write strobes), as if the serial management frames had already been decoded. A page-select register picks what the other 31 register numbers mean. Page 0 maps them onto a local 16-bit PHY register file. Page 4 maps a group of them onto bridge holding registers: a mode bit, separate write and read addresses, write data, and the captured read result. Any other page shows zeros and takes no writes.

Writing the low half of the write data starts an internal bus write. Writing the low half of the read address starts an internal bus read. Each internal transaction is one request held until an acknowledge arrives. Only one transaction is outstanding at a time. In auto-increment mode, the address used by a transaction steps by 4 when that transaction completes, so sequential words need only the data (or read-trigger) accesses.

Top module: `mgmt_page_bridge`

## Requirements
- R1: After reset, the page is 0, the mode is fixed-address, every bridge holding register and the read result read as 0, and no internal request is active.
- R2: Register 0x1F is the page select on every page. A write stores wdata[2:0], and a read returns the stored page in bits [2:0] with zeros above.
- R3: On page 0, registers 0x00 to 0x1E read and write a local 16-bit register file, and no internal bus request is made.
- R4: On a page other than 0 and 4, registers 0x00 to 0x1E read as 0 and writes change neither the register file nor any bridge register.
- R5: On page 4 the bridge registers are laid out as follows. Register 0x10 is the mode, with bit 15 = 1 for auto-increment; it reads back as bit 15 only. Registers 0x11 and 0x12 are write-address high and low, 0x13 and 0x14 are write-data high and low, and 0x15 and 0x16 are read-address high and low; all of these read back. Registers 0x17 and 0x18 return the high and low halves of the read result.
- R6: A page-4 write to 0x14 while idle issues an internal write. The address is {0x11,0x12}, and the data is {0x13, the value being written}.
- R7: A page-4 write to 0x16 while idle issues an internal read at {0x15, the value being written}. The acknowledged data becomes the read result.
- R8: Request, direction, address and write data stay constant until the acknowledge. The request drops in the cycle after the acknowledge.
- R9: While a transaction is outstanding, bridge_busy is high. Writes to 0x14 or 0x16 are stored but start nothing.
- R10: The read result changes only on a read acknowledge. A host read of 0x17 or 0x18 in the acknowledge cycle returns the previous result.
- R11: In auto-increment mode, the write (or read) address grows by 4 with carry across halves after each completed write (or read). In fixed mode it is unchanged.
- R12: A host write to either half of an address register in the cycle its increment is due sets that half to the host value. The other half keeps its value, and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_reg | input | 5 | Register number |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | High the cycle after a read strobe |
| bridge_busy | output | 1 | Internal transaction outstanding |
| ibus_req | output | 1 | Internal bus request |
| ibus_we | output | 1 | Internal bus direction, 1 = write |
| ibus_addr | output | 32 | Internal bus byte address |
| ibus_wdata | output | 32 | Internal bus write data |
| ibus_ack | input | 1 | Internal bus acknowledge |
| ibus_rdata | input | 32 | Internal bus read data, valid with ibus_ack |

## Verification
Two pairs of functions can meet in one cycle. The first pair is the capture of a read acknowledge and a host read of the result registers. The second pair is the auto-increment of an address and a host write to that same address. The bench provokes each one by waiting for the acknowledge from a slow internal-bus model, then strobing the host port in that same cycle. It judges the result by reading the registers afterwards: the old result must come back in the collision cycle, and the host-written address half must win over the step.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  localparam int REG_AW   = 5;
  localparam int HALF_W   = 16;
  localparam int PAGE_W   = 3;

  localparam logic [REG_AW-1:0] RN_PAGE  = 5'h1F;
  localparam logic [REG_AW-1:0] RN_MODE  = 5'h10;
  localparam logic [REG_AW-1:0] RN_WA_HI = 5'h11;
  localparam logic [REG_AW-1:0] RN_WA_LO = 5'h12;
  localparam logic [REG_AW-1:0] RN_WD_HI = 5'h13;
  localparam logic [REG_AW-1:0] RN_WD_LO = 5'h14;
  localparam logic [REG_AW-1:0] RN_RA_HI = 5'h15;
  localparam logic [REG_AW-1:0] RN_RA_LO = 5'h16;
  localparam logic [REG_AW-1:0] RN_RD_HI = 5'h17;
  localparam logic [REG_AW-1:0] RN_RD_LO = 5'h18;

  localparam logic [PAGE_W-1:0] PG_LOCAL  = 3'd0;
  localparam logic [PAGE_W-1:0] PG_BRIDGE = 3'd4;
endpackage

// File: rtl/mpb_phy_file.sv
module mpb_phy_file #(
  parameter int DW    = 16,
  parameter int AW    = 5,
  parameter int DEPTH = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic en;
    logic [DW-1:0] q;
    assign en = wr_en && (addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign ent[i] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (addr == AW'(i)) rdata = ent[i];
    end
  end
endmodule

// File: rtl/mpb_window_regs.sv
module mpb_window_regs
  import mpb_pkg::*;
#(
  parameter int HDW       = 16,
  parameter int ADDR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] reg_sel,
  input  logic [HDW-1:0]    wdata,
  input  logic              busy,
  input  logic              done_wr,
  input  logic              done_rd,
  input  logic [2*HDW-1:0]  rd_result,
  output logic [HDW-1:0]    rd_val,
  output logic              launch_wr,
  output logic              launch_rd,
  output logic [2*HDW-1:0]  cmd_addr,
  output logic [2*HDW-1:0]  cmd_data
);
  localparam int FW = 2 * HDW;
  localparam logic [FW-1:0] STEP = FW'(ADDR_STEP);

  logic          mode_q, mode_d;
  logic [FW-1:0] wa_q, wa_d, ra_q, ra_d, wd_q, wd_d;
  logic          host_wa, host_ra;

  assign host_wa = wr_en && (reg_sel == RN_WA_HI || reg_sel == RN_WA_LO);
  assign host_ra = wr_en && (reg_sel == RN_RA_HI || reg_sel == RN_RA_LO);

  assign launch_wr = wr_en && (reg_sel == RN_WD_LO) && !busy;
  assign launch_rd = wr_en && (reg_sel == RN_RA_LO) && !busy;
  assign cmd_addr  = launch_rd ? {ra_q[FW-1:HDW], wdata} : wa_q;
  assign cmd_data  = {wd_q[FW-1:HDW], wdata};

  always_comb begin
    mode_d = mode_q;
    wa_d   = wa_q;
    ra_d   = ra_q;
    wd_d   = wd_q;
    if (done_wr && mode_q) wa_d = wa_q + STEP;
    if (done_rd && mode_q) ra_d = ra_q + STEP;
    if (wr_en) begin
      unique case (reg_sel)
        RN_MODE:  mode_d = wdata[HDW-1];
        RN_WA_HI: wa_d = {wdata, wa_q[HDW-1:0]};
        RN_WA_LO: wa_d = {wa_q[FW-1:HDW], wdata};
        RN_WD_HI: wd_d = {wdata, wd_q[HDW-1:0]};
        RN_WD_LO: wd_d = {wd_q[FW-1:HDW], wdata};
        RN_RA_HI: ra_d = {wdata, ra_q[HDW-1:0]};
        RN_RA_LO: ra_d = {ra_q[FW-1:HDW], wdata};
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      wa_q   <= '0;
      ra_q   <= '0;
      wd_q   <= '0;
    end else begin
      mode_q <= mode_d;
      wa_q   <= wa_d;
      ra_q   <= ra_d;
      wd_q   <= wd_d;
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (reg_sel)
      RN_MODE:  rd_val[HDW-1] = mode_q;
      RN_WA_HI: rd_val = wa_q[FW-1:HDW];
      RN_WA_LO: rd_val = wa_q[HDW-1:0];
      RN_WD_HI: rd_val = wd_q[FW-1:HDW];
      RN_WD_LO: rd_val = wd_q[HDW-1:0];
      RN_RA_HI: rd_val = ra_q[FW-1:HDW];
      RN_RA_LO: rd_val = ra_q[HDW-1:0];
      RN_RD_HI: rd_val = rd_result[FW-1:HDW];
      RN_RD_LO: rd_val = rd_result[HDW-1:0];
      default:  rd_val = '0;
    endcase
  end

  AST_FIXED_WA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !host_wa) |=> $stable(wa_q)); // R11
  AST_FIXED_RA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !host_ra) |=> $stable(ra_q)); // R11
  AST_WA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_wr && mode_q && !host_wa) |=> wa_q == $past(wa_q) + STEP); // R11
  AST_HOST_WINS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == RN_WA_LO) |=> wa_q[HDW-1:0] == $past(wdata)); // R12
endmodule

// File: rtl/mpb_ibus_master.sv
module mpb_ibus_master #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_wr,
  input  logic          launch_rd,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          ibus_ack,
  input  logic [DW-1:0] ibus_rdata,
  output logic          ibus_req,
  output logic          ibus_we,
  output logic [AW-1:0] ibus_addr,
  output logic [DW-1:0] ibus_wdata,
  output logic          done_wr,
  output logic          done_rd,
  output logic [DW-1:0] rd_result
);
  logic          req_q, req_d, we_q, we_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d, res_q, res_d;
  logic          start, complete;

  assign start    = (launch_wr || launch_rd) && !req_q;
  assign complete = req_q && ibus_ack;
  assign done_wr  = complete && we_q;
  assign done_rd  = complete && !we_q;

  always_comb begin
    req_d  = req_q;
    we_d   = we_q;
    addr_d = addr_q;
    data_d = data_q;
    res_d  = res_q;
    if (complete) begin
      req_d = 1'b0;
      if (!we_q) res_d = ibus_rdata;
    end else if (start) begin
      req_d  = 1'b1;
      we_d   = launch_wr;
      addr_d = cmd_addr;
      data_d = launch_wr ? cmd_data : data_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      res_q  <= '0;
    end else begin
      req_q  <= req_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      data_q <= data_d;
      res_q  <= res_d;
    end
  end

  assign ibus_req   = req_q;
  assign ibus_we    = we_q;
  assign ibus_addr  = addr_q;
  assign ibus_wdata = data_q;
  assign rd_result  = res_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_req && !ibus_ack) |=> (ibus_req && $stable(ibus_addr) && $stable(ibus_we) && $stable(ibus_wdata))); // R8
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_req && ibus_ack) |=> !ibus_req); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ibus_req && ibus_ack && !ibus_we) |=> $stable(rd_result)); // R10
  AST_RESULT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_req && ibus_ack && !ibus_we) |=> rd_result == $past(ibus_rdata)); // R7
endmodule

// File: rtl/mgmt_page_bridge.sv
module mgmt_page_bridge
  import mpb_pkg::*;
#(
  parameter int HDW       = 16,
  parameter int PHY_DEPTH = 31,
  parameter int ADDR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [REG_AW-1:0] host_reg,
  input  logic [HDW-1:0]    host_wdata,
  output logic [HDW-1:0]    host_rdata,
  output logic              host_rvalid,
  output logic              bridge_busy,
  output logic              ibus_req,
  output logic              ibus_we,
  output logic [2*HDW-1:0]  ibus_addr,
  output logic [2*HDW-1:0]  ibus_wdata,
  input  logic              ibus_ack,
  input  logic [2*HDW-1:0]  ibus_rdata
);
  localparam int FW = 2 * HDW;

  logic [PAGE_W-1:0] page_q, page_d;
  logic              page_en, phy_we, win_we;
  logic [HDW-1:0]    phy_rval, win_rval, rdata_d, rdata_q;
  logic              rvalid_q;
  logic              launch_wr, launch_rd, done_wr, done_rd;
  logic [FW-1:0]     cmd_addr, cmd_data, rd_result;

  assign page_en = host_wr && (host_reg == RN_PAGE);
  assign phy_we  = host_wr && (host_reg != RN_PAGE) && (page_q == PG_LOCAL);
  assign win_we  = host_wr && (host_reg != RN_PAGE) && (page_q == PG_BRIDGE);

  always_comb begin
    page_d = page_q;
    if (page_en) page_d = host_wdata[PAGE_W-1:0];
  end

  always_comb begin
    rdata_d = '0;
    if (host_reg == RN_PAGE)         rdata_d[PAGE_W-1:0] = page_q;
    else if (page_q == PG_LOCAL)     rdata_d = phy_rval;
    else if (page_q == PG_BRIDGE)    rdata_d = win_rval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      page_q   <= page_d;
      rvalid_q <= host_rd;
      if (host_rd) rdata_q <= rdata_d;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;
  assign bridge_busy = ibus_req;

  mpb_phy_file #(.DW(HDW), .AW(REG_AW), .DEPTH(PHY_DEPTH)) u_phy (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (phy_we),
    .addr  (host_reg),
    .wdata (host_wdata),
    .rdata (phy_rval)
  );

  mpb_window_regs #(.HDW(HDW), .ADDR_STEP(ADDR_STEP)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (win_we),
    .reg_sel   (host_reg),
    .wdata     (host_wdata),
    .busy      (ibus_req),
    .done_wr   (done_wr),
    .done_rd   (done_rd),
    .rd_result (rd_result),
    .rd_val    (win_rval),
    .launch_wr (launch_wr),
    .launch_rd (launch_rd),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data)
  );

  mpb_ibus_master #(.AW(FW), .DW(FW)) u_mst (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_wr  (launch_wr),
    .launch_rd  (launch_rd),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .ibus_ack   (ibus_ack),
    .ibus_rdata (ibus_rdata),
    .ibus_req   (ibus_req),
    .ibus_we    (ibus_we),
    .ibus_addr  (ibus_addr),
    .ibus_wdata (ibus_wdata),
    .done_wr    (done_wr),
    .done_rd    (done_rd),
    .rd_result  (rd_result)
  );

  AST_REQ_ONLY_FROM_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibus_req) |-> $past(page_q) == PG_BRIDGE); // R3
  AST_BUSY_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_req && !ibus_ack && host_wr && host_reg == RN_WD_LO) |=> (ibus_req && $stable(ibus_wdata))); // R9
  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    page_en |=> page_q == $past(host_wdata[PAGE_W-1:0])); // R2
  AST_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid); // R2
endmodule

// File: tb/mgmt_page_bridge_test.sv
`timescale 1ns/1ps
module mgmt_page_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_rd;
  logic [4:0]  host_reg;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        host_rvalid, bridge_busy;
  logic        ibus_req, ibus_we, ibus_ack;
  logic [31:0] ibus_addr, ibus_wdata, ibus_rdata;

  int checks = 0;
  int errors = 0;
  int slave_lat = 0;
  int cnt;
  logic [31:0] mem [256];

  logic [15:0] rq_exp[$];
  string       rq_tag[$];
  logic        bq_we[$];
  logic [31:0] bq_addr[$];
  logic [31:0] bq_data[$];
  string       bq_tag[$];

  always #2.5 clk = ~clk;

  mgmt_page_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .bridge_busy(bridge_busy), .ibus_req(ibus_req),
    .ibus_we(ibus_we), .ibus_addr(ibus_addr), .ibus_wdata(ibus_wdata),
    .ibus_ack(ibus_ack), .ibus_rdata(ibus_rdata)
  );

  // internal bus slave model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibus_ack   <= 1'b0;
      ibus_rdata <= '0;
      cnt        <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else if (ibus_ack) begin
      ibus_ack <= 1'b0;
      cnt      <= 0;
      if (ibus_we && ibus_addr != 32'h1000_5000) mem[ibus_addr[9:2]] <= ibus_wdata;
    end else if (ibus_req) begin
      if (cnt >= slave_lat) begin
        ibus_ack   <= 1'b1;
        ibus_rdata <= (ibus_addr == 32'h1000_5000) ? 32'h0000_8855 : mem[ibus_addr[9:2]];
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: host read responses
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (rq_exp.size() == 0) check(32'h1, 32'h0, "R2 unexpected read response");
      else check({16'h0, host_rdata}, {16'h0, rq_exp.pop_front()}, rq_tag.pop_front());
    end
  end

  // monitor: internal bus transactions
  always @(negedge clk) begin
    if (rst_n && ibus_req && ibus_ack) begin
      if (bq_we.size() == 0) begin
        check(ibus_addr, 32'hxxxx_xxxx, "R9 unexpected internal transaction");
      end else begin
        logic        e_we;
        logic [31:0] e_a, e_d;
        string       t;
        e_we = bq_we.pop_front();
        e_a  = bq_addr.pop_front();
        e_d  = bq_data.pop_front();
        t    = bq_tag.pop_front();
        check({31'h0, ibus_we}, {31'h0, e_we}, {t, " dir"});
        check(ibus_addr, e_a, {t, " addr"});
        if (e_we) check(ibus_wdata, e_d, {t, " data"});
      end
    end
  end

  task automatic hwrite(input logic [4:0] r, input logic [15:0] d);
    host_wr = 1'b1; host_reg = r; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [4:0] r, input logic [15:0] exp, input string tag);
    rq_exp.push_back(exp); rq_tag.push_back(tag);
    host_rd = 1'b1; host_reg = r;
    @(posedge clk); #1;
    host_rd = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic expect_bus(input logic we, input logic [31:0] a, input logic [31:0] d, input string tag);
    bq_we.push_back(we); bq_addr.push_back(a); bq_data.push_back(d); bq_tag.push_back(tag);
  endtask

  task automatic wait_idle();
    do begin @(posedge clk); #1; end while (ibus_req);
  endtask

  task automatic wait_ack();
    @(negedge clk);
    while (!ibus_ack) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_reg = '0; host_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    check({31'h0, ibus_req}, 32'h0, "R1 no request after reset");
    check({31'h0, bridge_busy}, 32'h0, "R1 not busy after reset");
    hread(5'h1F, 16'h0000, "R1 page is 0");
    hwrite(5'h1F, 16'h0004);
    hread(5'h10, 16'h0000, "R1 mode fixed");
    hread(5'h11, 16'h0000, "R1 wa hi");
    hread(5'h12, 16'h0000, "R1 wa lo");
    hread(5'h14, 16'h0000, "R1 wd lo");
    hread(5'h16, 16'h0000, "R1 ra lo");
    hread(5'h18, 16'h0000, "R1 result lo");

    // R2 page select masking
    hwrite(5'h1F, 16'hFFF1);
    hread(5'h1F, 16'h0001, "R2 page readback masked");

    // R3 local register file on page 0
    hwrite(5'h1F, 16'h0000);
    hwrite(5'h05, 16'hBEEF);
    hread(5'h05, 16'hBEEF, "R3 local file write/read");
    hwrite(5'h14, 16'h5555);
    hwrite(5'h16, 16'h6666);
    hread(5'h14, 16'h5555, "R3 reg 0x14 is local on page 0");
    hread(5'h16, 16'h6666, "R3 reg 0x16 is local on page 0");
    repeat (4) @(posedge clk); #1;
    check({31'h0, ibus_req}, 32'h0, "R3 no bridge request on page 0");

    // R4 other page
    hwrite(5'h1F, 16'h0001);
    hwrite(5'h05, 16'h1111);
    hwrite(5'h12, 16'h7777);
    hread(5'h05, 16'h0000, "R4 page 1 reads zero");
    hwrite(5'h1F, 16'h0000);
    hread(5'h05, 16'hBEEF, "R4 local file untouched");
    hwrite(5'h1F, 16'h0004);
    hread(5'h12, 16'h0000, "R4 bridge reg untouched");

    // R5/R6 write transaction
    hwrite(5'h10, 16'h0000);
    hwrite(5'h11, 16'h1234);
    hwrite(5'h12, 16'h5678);
    hread(5'h11, 16'h1234, "R5 wa hi readback");
    hread(5'h12, 16'h5678, "R5 wa lo readback");
    hwrite(5'h11, 16'h0000);
    hwrite(5'h12, 16'h0010);
    hwrite(5'h13, 16'hCAFE);
    expect_bus(1'b1, 32'h0000_0010, 32'hCAFE_F00D, "R6 write launch");
    hwrite(5'h14, 16'hF00D);
    wait_idle();
    hread(5'h13, 16'hCAFE, "R5 wd hi readback");
    hread(5'h14, 16'hF00D, "R5 wd lo readback");

    // R7 read transactions
    hwrite(5'h15, 16'h0000);
    expect_bus(1'b0, 32'h0000_0010, 32'h0, "R7 read launch");
    hwrite(5'h16, 16'h0010);
    wait_idle();
    hread(5'h17, 16'hCAFE, "R7 result hi");
    hread(5'h18, 16'hF00D, "R7 result lo");
    hwrite(5'h15, 16'h1000);
    expect_bus(1'b0, 32'h1000_5000, 32'h0, "R7 id read launch");
    hwrite(5'h16, 16'h5000);
    wait_idle();
    hread(5'h17, 16'h0000, "R7 id hi");
    hread(5'h18, 16'h8855, "R7 id lo");
    hread(5'h16, 16'h5000, "R11 fixed ra unchanged");
    hread(5'h12, 16'h0010, "R11 fixed wa unchanged");

    // R11 auto-increment
    hwrite(5'h10, 16'h8000);
    hread(5'h10, 16'h8000, "R5 mode readback");
    hwrite(5'h12, 16'h0020);
    hwrite(5'h13, 16'h1111);
    expect_bus(1'b1, 32'h0000_0020, 32'h1111_2222, "R6 inc write 1");
    hwrite(5'h14, 16'h2222);
    wait_idle();
    hread(5'h12, 16'h0024, "R11 wa stepped");
    expect_bus(1'b1, 32'h0000_0024, 32'h1111_3333, "R11 inc write 2");
    hwrite(5'h14, 16'h3333);
    wait_idle();
    hread(5'h12, 16'h0028, "R11 wa stepped again");
    hwrite(5'h15, 16'h0000);
    expect_bus(1'b0, 32'h0000_0020, 32'h0, "R7 inc read");
    hwrite(5'h16, 16'h0020);
    wait_idle();
    hread(5'h16, 16'h0024, "R11 ra stepped");
    hread(5'h18, 16'h2222, "R7 inc read data");
    hwrite(5'h11, 16'h0001);
    hwrite(5'h12, 16'hFFFC);
    expect_bus(1'b1, 32'h0001_FFFC, 32'h1111_0101, "R6 carry write");
    hwrite(5'h14, 16'h0101);
    wait_idle();
    hread(5'h11, 16'h0002, "R11 carry into hi");
    hread(5'h12, 16'h0000, "R11 carry lo");

    // R8/R9 busy
    slave_lat = 6;
    hwrite(5'h11, 16'h0000);
    hwrite(5'h12, 16'h0040);
    expect_bus(1'b1, 32'h0000_0040, 32'h1111_AAAA, "R8 slow write");
    hwrite(5'h14, 16'hAAAA);
    check({31'h0, bridge_busy}, 32'h1, "R9 busy while outstanding");
    hwrite(5'h14, 16'hBBBB);
    check(ibus_wdata, 32'h1111_AAAA, "R8 data held while busy");
    check({31'h0, ibus_req}, 32'h1, "R8 request held");
    wait_idle();
    check({31'h0, bridge_busy}, 32'h0, "R9 busy clears");
    hread(5'h14, 16'hBBBB, "R9 busy write still stored");
    hread(5'h12, 16'h0044, "R11 single step after ignored launch");

    // R10 collision: host read in ack cycle
    slave_lat = 3;
    hwrite(5'h10, 16'h0000);
    hwrite(5'h15, 16'h0001);
    expect_bus(1'b0, 32'h0001_FFFC, 32'h0, "R7 slow read");
    hwrite(5'h16, 16'hFFFC);
    wait_ack();
    rq_exp.push_back(16'h2222); rq_tag.push_back("R10 old result in ack cycle");
    host_rd = 1'b1; host_reg = 5'h18;
    @(posedge clk); #1;
    host_rd = 1'b0;
    @(posedge clk); #1;
    hread(5'h18, 16'h0101, "R10 new result after ack");

    // R12 collision: host address write in increment cycle
    hwrite(5'h10, 16'h8000);
    hwrite(5'h11, 16'h0000);
    hwrite(5'h12, 16'h0080);
    expect_bus(1'b1, 32'h0000_0080, 32'h1111_5A5A, "R6 slow inc write");
    hwrite(5'h14, 16'h5A5A);
    wait_ack();
    host_wr = 1'b1; host_reg = 5'h12; host_wdata = 16'h0300;
    @(posedge clk); #1;
    host_wr = 1'b0;
    hread(5'h12, 16'h0300, "R12 host lo wins");
    hread(5'h11, 16'h0000, "R12 hi kept");

    repeat (10) @(posedge clk); #1;
    check(bq_we.size(), 32'h0, "R9 all expected transactions seen");
    check(rq_exp.size(), 32'h0, "R2 all reads answered");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule